// File: doc/BRIEF.md
# Interrupt Cause and Mask Aggregator

This block collects thirty-two level-sensitive interrupt sources into one combined request line. Each source owns a single bit in a cause register, which latches the request, and a matching bit in a mask register, which decides whether that source may reach the output. The combined line is the registered OR of every bit that is both latched and enabled. It is meant to drive one input of an upstream interrupt controller, which treats it as a level-type cascaded line.

Software reaches the block through a plain valid/write/address/data port. It enables a source by setting its mask bit. It acknowledges a source by writing a one to that source's cause bit. Because the sources are level-sensitive, a source that is still asserted sets its bit again on the next clock. A read-only helper register gives the index of the lowest-numbered source that is both pending and enabled, so the handler needs no bit scan of its own. A quiesce sequence writes zero to the mask and all ones to the cause register, which leaves the block fully disabled and clean.

Top module: `irq_cause_mask_ctrl`

## Requirements
- R1: After reset the cause register reads 0, the mask register reads 0, irq_o is 0, and the helper register reads 0x8000_0000.
- R2: A write to byte offset 0x00 clears every cause bit written as 1 whose source is low. Cause bits written as 0 keep their value. A cause bit never becomes set unless its source was high at the previous clock edge.
- R3: A source that is high at a clock edge has its cause bit set after that edge. When an acknowledge of the same bit happens at that edge, the set takes priority.
- R4: A write to byte offset 0x04 loads the mask register with the written data. A 1 enables a source and a 0 disables it. The mask changes at no other time.
- R5: irq_o is 1 exactly when some bit is set in both cause and mask, and it follows that condition with one clock of delay.
- R6: A read of byte offset 0x08 returns the helper register. Bits [4:0] hold the lowest index set in (cause AND mask). Bit 31 is 1 when that AND is zero, and in that case bits [4:0] are 0. All other bits are 0.
- R7: Writes to offset 0x08, and writes to any offset other than 0x00 and 0x04, change neither register.
- R8: With all sources low, writing 0 to offset 0x04 and then 0xFFFF_FFFF to offset 0x00 leaves cause 0 and mask 0. After that the helper reads 0x8000_0000 and irq_o is 0.
- R9: A read (valid high, write low) of offset 0x00 returns the cause register and a read of offset 0x04 returns the mask register. A read of any unmapped offset returns 0. rdata is 0 whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources, bit n is source n |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the current register state |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Two functions can land on the same cause bit in one clock: the level set from a source that is still high, and the write-one acknowledge from software. The bench holds a source high while it writes a one to that same bit, for every source in turn. It then reads the cause register back and expects the bit to remain set, while a sister bit with its source low, acknowledged in the same write, must read as cleared. The priority encoder is swept over every pair of sources, both with all sources enabled and with the lower source of each pair masked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 32;

    localparam int OFS_CAUSE = 'h0;
    localparam int OFS_MASK  = 'h4;
    localparam int OFS_FIRST = 'h8;

    // Flag bit in the helper register that reports "nothing pending".
    localparam int NONE_BIT = 31;

    typedef enum logic [1:0] {
        SEL_CAUSE,
        SEL_MASK,
        SEL_FIRST,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] ack_i,
    input  logic            mask_we_i,
    input  logic [NSRC-1:0] mask_wdata_i,
    output logic [NSRC-1:0] cause_o,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] pend_o
);

    typedef struct packed {
        logic [NSRC-1:0] cause;
        logic [NSRC-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Acknowledge first, then the level set, so the set wins on a tie.
        st_d.cause = (st_q.cause & ~ack_i) | src_i;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign pend_o  = st_q.cause & st_q.mask;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (st_q.cause == '0 && st_q.mask == '0));

    p_level_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((st_q.cause & $past(src_i)) == $past(src_i)));

    p_ack_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_i & ~src_i) != '0) |=> ((st_q.cause & $past(ack_i & ~src_i)) == '0));

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cause != '1) |=> ((st_q.cause & ~$past(st_q.cause) & ~$past(src_i)) == '0));

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(st_q.mask));

endmodule

// File: rtl/irqc_first_enc.sv
module irqc_first_enc #(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             none_o
);

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (pend_i[k]) begin
                idx_o = IDX_W'(k);
            end
        end
        none_o = (pend_i == '0);
    end

endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_i,
    output logic            irq_o
);

    typedef struct packed {
        logic irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |pend_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/irq_cause_mask_ctrl.sv
module irq_cause_mask_ctrl #(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            src_i,
    input  logic                       bus_valid_i,
    input  logic                       bus_write_i,
    input  logic [ADDR_W-1:0]          bus_addr_i,
    input  logic [irqc_pkg::DATA_W-1:0] bus_wdata_i,
    output logic [irqc_pkg::DATA_W-1:0] bus_rdata_o,
    output logic                       irq_o
);
    import irqc_pkg::*;

    localparam int IDX_W = $clog2(NSRC);

    reg_sel_e          sel;
    logic              wr_en;
    logic              rd_en;
    logic [NSRC-1:0]   ack;
    logic              mask_we;
    logic [NSRC-1:0]   cause;
    logic [NSRC-1:0]   mask;
    logic [NSRC-1:0]   pend;
    logic [IDX_W-1:0]  first_idx;
    logic              first_none;
    logic [DATA_W-1:0] first_word;

    always_comb begin
        if (bus_addr_i == ADDR_W'(OFS_CAUSE)) begin
            sel = SEL_CAUSE;
        end else if (bus_addr_i == ADDR_W'(OFS_MASK)) begin
            sel = SEL_MASK;
        end else if (bus_addr_i == ADDR_W'(OFS_FIRST)) begin
            sel = SEL_FIRST;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign wr_en   = bus_valid_i && bus_write_i;
    assign rd_en   = bus_valid_i && !bus_write_i;
    assign ack     = (wr_en && sel == SEL_CAUSE) ? bus_wdata_i[NSRC-1:0] : '0;
    assign mask_we = wr_en && (sel == SEL_MASK);

    irqc_regs #(.NSRC(NSRC)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i),
        .ack_i        (ack),
        .mask_we_i    (mask_we),
        .mask_wdata_i (bus_wdata_i[NSRC-1:0]),
        .cause_o      (cause),
        .mask_o       (mask),
        .pend_o       (pend)
    );

    irqc_first_enc #(.NSRC(NSRC), .IDX_W(IDX_W)) u_enc (
        .pend_i (pend),
        .idx_o  (first_idx),
        .none_o (first_none)
    );

    irqc_irq_out #(.NSRC(NSRC)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .irq_o  (irq_o)
    );

    always_comb begin
        first_word = '0;
        if (first_none) begin
            first_word[NONE_BIT] = 1'b1;
        end else begin
            first_word[IDX_W-1:0] = first_idx;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (rd_en) begin
            case (sel)
                SEL_CAUSE: bus_rdata_o = DATA_W'(cause);
                SEL_MASK:  bus_rdata_o = DATA_W'(mask);
                SEL_FIRST: bus_rdata_o = first_word;
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    p_irq_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past((cause & mask) != '0)));

    p_first_is_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !first_none |-> (pend[first_idx] &&
                         ((pend & ((NSRC'(1) << first_idx) - NSRC'(1))) == '0)));

    p_none_means_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        first_none |-> ((cause & mask) == '0));

    p_first_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel != SEL_MASK) |=> $stable(mask));

endmodule

// File: tb/tb_irq_cause_mask_ctrl.sv
module tb_irq_cause_mask_ctrl;

    localparam int NSRC = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        valid = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_cause_mask_ctrl #(.NSRC(NSRC), .ADDR_W(4)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_valid_i (valid),
        .bus_write_i (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] helper_exp(input logic [31:0] p);
        logic [31:0] r;
        r = 32'h8000_0000;
        for (int k = 31; k >= 0; k--) begin
            if (p[k]) r = 32'(k);
        end
        return r;
    endfunction

    // One clock step: inputs are changed at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        valid = 1'b1; wr = 1'b1; addr = a; wdata = d;
        step();
        valid = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        valid = 1'b1; wr = 1'b0; addr = a;
        #1;
        d = rdata;
        valid = 1'b0;
        #1;
    endtask

    // Latches the pattern p for one clock and then lowers every source.
    task automatic pulse_src(input logic [31:0] p);
        src = p;
        step();
        src = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(4'h0, d); check("R1 cause", d, 32'h0);
        bus_rd(4'h4, d); check("R1 mask", d, 32'h0);
        bus_rd(4'h8, d); check("R1 helper", d, 32'h8000_0000);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R9: unmapped and idle reads
        bus_rd(4'hC, d); check("R9 unmapped read", d, 32'h0);
        check("R9 idle rdata", rdata, 32'h0);

        // R4: mask write sweep
        for (int i = 0; i < NSRC; i++) begin
            bus_wr(4'h4, 32'h1 << i);
            bus_rd(4'h4, d); check("R4 mask single bit", d, 32'h1 << i);
        end
        bus_wr(4'h4, 32'hA5A5_0F0F);
        bus_rd(4'h4, d); check("R4 mask pattern", d, 32'hA5A5_0F0F);

        // Masked pending: no output, helper reports none
        bus_wr(4'h4, 32'h0);
        pulse_src(32'h0000_0010);
        step();
        check("R5 masked irq low", {31'b0, irq}, 32'h0);
        bus_rd(4'h8, d); check("R6 masked helper none", d, 32'h8000_0000);
        bus_rd(4'h0, d); check("R3 masked cause latched", d, 32'h0000_0010);
        bus_wr(4'h0, 32'hFFFF_FFFF);

        // Single-source sweep: latch, helper, irq latency, set-wins, ack
        bus_wr(4'h4, 32'hFFFF_FFFF);
        for (int i = 0; i < NSRC; i++) begin
            logic [31:0] b;
            b = 32'h1 << i;
            src = b;
            step();
            bus_rd(4'h0, d); check("R3 level latch", d, b);
            bus_rd(4'h8, d); check("R6 helper single", d, 32'(i));
            check("R5 irq one clock late", {31'b0, irq}, 32'h0);
            step();
            check("R5 irq rises", {31'b0, irq}, 32'h1);
            // Acknowledge while held high, plus a neighbour whose source is low.
            bus_wr(4'h0, b | (32'h1 << ((i + 1) % NSRC)));
            bus_rd(4'h0, d); check("R3 set wins over ack", d, b);
            src = '0;
            bus_wr(4'h0, b);
            bus_rd(4'h0, d); check("R2 ack clears", d, 32'h0);
            step();
            check("R5 irq falls", {31'b0, irq}, 32'h0);
        end

        // R2: zero bits in an acknowledge are untouched
        pulse_src(32'hFFFF_FFFF);
        bus_wr(4'h0, 32'h5555_5555);
        bus_rd(4'h0, d); check("R2 partial ack", d, 32'hAAAA_AAAA);
        bus_wr(4'h0, 32'h0);
        bus_rd(4'h0, d); check("R2 zero ack no effect", d, 32'hAAAA_AAAA);
        bus_wr(4'h0, 32'hFFFF_FFFF);

        // R6: pair sweep, all enabled and with the lower source masked
        for (int i = 0; i < NSRC; i++) begin
            for (int j = i + 1; j < NSRC; j++) begin
                logic [31:0] p;
                p = (32'h1 << i) | (32'h1 << j);
                bus_wr(4'h4, 32'hFFFF_FFFF);
                pulse_src(p);
                bus_rd(4'h8, d); check("R6 lowest of pair", d, helper_exp(p));
                bus_wr(4'h4, ~(32'h1 << i));
                bus_rd(4'h8, d); check("R6 lower masked", d, helper_exp(p & ~(32'h1 << i)));
                bus_wr(4'h0, 32'hFFFF_FFFF);
            end
        end

        // R7: writes to the helper and unmapped offsets are ignored
        bus_wr(4'h4, 32'h0F0F_0F0F);
        pulse_src(32'h0000_0300);
        bus_wr(4'h8, 32'hFFFF_FFFF);
        bus_wr(4'hC, 32'hFFFF_FFFF);
        bus_wr(4'h2, 32'hFFFF_FFFF);
        bus_rd(4'h0, d); check("R7 cause unchanged", d, 32'h0000_0300);
        bus_rd(4'h4, d); check("R7 mask unchanged", d, 32'h0F0F_0F0F);
        bus_rd(4'h8, d); check("R7 helper unchanged", d, 32'h8);

        // R8: quiesce
        bus_wr(4'h4, 32'h0);
        bus_wr(4'h0, 32'hFFFF_FFFF);
        step();
        bus_rd(4'h0, d); check("R8 cause cleared", d, 32'h0);
        bus_rd(4'h4, d); check("R8 mask cleared", d, 32'h0);
        bus_rd(4'h8, d); check("R8 helper none", d, 32'h8000_0000);
        check("R8 irq low", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule